// File: doc/BRIEF.md
# Character display instruction decoder

This block models the register side of a character display controller. A host sends one byte per transfer over a synchronous port. Each transfer is qualified by a data/instruction select line and a read/write line. The block decodes instruction bytes and keeps the mode registers and a shared address counter. It stores characters in an 80-byte display RAM and glyph rows in a 64-entry, 5-bit pattern RAM. A busy flag tells the host when the next transfer is accepted. Pixel scanning, the character ROM and the analogue bus timing belong to other blocks.

The display RAM is seen through two row windows: 0x00..0x27 and 0x40..0x67. The addresses between and after them form a gap. When the counter steps, it jumps across the gap. The last set-address instruction decides whether data transfers reach the display RAM or the pattern RAM.

The control path is a three-state machine:
- `ST_READY` accepts transfers.
- `ST_WIPE` sweeps the display RAM with spaces after a clear.
- `ST_HOLD` counts down the remaining busy time.

Its transitions are:
- READY→WIPE on an accepted clear.
- READY→HOLD on any other accepted transfer.
- WIPE→HOLD once the last display location is written.
- HOLD→READY when the busy counter reaches one.

Top module: `chardisp_ctrl`

## Requirements
- R1: After reset the outputs are as follows: busy=0, err=0, rdata=0x00, disp_ofs=0, and the address counter is 0 with the display RAM selected. The mode is 0x82, with these bits: mode[7]=8-bit bus, mode[6]=two lines, mode[5]=tall font, mode[4]=display on, mode[3]=cursor on, mode[2]=blink, mode[1]=increment, mode[0]=shift on write.
- R2: With sel_data=0 and rd_nwr=0 the byte is an instruction, decoded by its highest set bit:
  - 0x01 is clear.
  - 0000001x is home.
  - 000001ab is entry mode: a→mode[1], b→mode[0].
  - 00001dcb is display control: d,c,b→mode[4:2].
  - 0001sr00 is shift.
  - 001lnf00 is function set: l,n,f→mode[7:5].
  - 01aaaaaa sets the pattern address.
  - 1aaaaaaa sets the display address.
  - 0x00 has no effect and does not raise busy.
- R3: A status read (sel_data=0, rd_nwr=1) is served in any state. The cycle after the strobe it puts {busy, address counter[6:0]} on rdata. It never raises busy or err.
- R4: A data write (sel_data=1, rd_nwr=0) stores the byte at the counter in the selected RAM. A data read (sel_data=1, rd_nwr=1) puts the stored byte on rdata the next cycle. Both then step the counter by one in the direction of mode[1] (1 forward, 0 backward).
- R5: In the display RAM, a forward step goes 0x27→0x40 and 0x67 (or any higher address)→0x00. A backward step goes 0x40→0x27 and 0x00 (or above 0x67)→0x67.
- R6: A set-address instruction selects the RAM for later data transfers. A pattern address is 6 bits and steps modulo 64. Pattern accesses leave the display RAM untouched.
- R7: Pattern entries are 5 bits. A write keeps bits 4:0, and a read returns {3'b000, entry}.
- R8: An accepted transfer raises busy from the next cycle. Busy stays high for SHORT_CYC cycles (default 4), or LONG_CYC cycles (default 96) for clear and home.
- R9: While busy, any transfer other than a status read is dropped. It sets err, which stays 1 until reset.
- R10: Clear writes 0x20 to all 80 display locations. Clear and home both set the counter to 0, set disp_ofs to 0 and select the display RAM. Home leaves both RAMs unchanged.
- R11: A shift with s=1 moves disp_ofs by +1 if r=1, else by -1, modulo 40. With s=0 it steps the counter as in R5, forward when r=1. With mode[0]=1, each data write also moves disp_ofs by +1 when mode[1]=1, else by -1.
- R12: A data transfer at a display address in the gap (0x28..0x3F, 0x68..0x7F) writes nothing and reads 0x00. The counter still steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | Transfer strobe, one cycle per byte |
| sel_data | input | 1 | 1 = data transfer, 0 = instruction/status |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| wdata | input | 8 | Byte from host |
| rdata | output | 8 | Read result, valid the cycle after a read strobe |
| busy | output | 1 | Internal operation in progress |
| err | output | 1 | Sticky flag: a transfer arrived while busy |
| mode | output | 8 | Mode register bits, layout in R1 |
| disp_ofs | output | 6 | Display shift offset, 0..ROW_LEN-1 |

## Verification
The hardest situations to reach from the ports are a transfer arriving inside the busy window and the counter stepping across the row gap in both directions.

For the first, the stimulus issues a second strobe on the cycle right after an accepted one, before waiting for busy to drop. That produces both a rejected write and a status read that must show bit 7 set. A later readback of the targeted location proves the dropped byte never landed.

For the second, the counter is parked on each row edge and stepped both by data transfers and by the cursor-shift instruction. It is then read through the status path. Clear is checked by reading back all 80 locations, which walks the counter across the gap and back to zero.

// File: rtl/chardisp_pkg.sv
package chardisp_pkg;

    typedef enum logic [3:0] {
        OP_NONE, OP_CLEAR, OP_HOME, OP_ENTRY, OP_DISPCTL, OP_SHIFT,
        OP_FUNC, OP_SETCG, OP_SETDD, OP_WDATA, OP_RDATA, OP_STATUS
    } op_e;

    typedef enum logic [1:0] {
        ST_READY, ST_WIPE, ST_HOLD
    } st_e;

    typedef struct packed {
        logic bus8;
        logic two_line;
        logic font10;
        logic disp_on;
        logic cur_on;
        logic blink_on;
        logic inc;
        logic shift_en;
    } mode_t;

    localparam logic [7:0] MODE_RESET = 8'h82;
    localparam logic [7:0] BLANK_CHAR = 8'h20;

endpackage

// File: rtl/chardisp_decode.sv
module chardisp_decode
    import chardisp_pkg::*;
(
    input  logic       rs,
    input  logic       rw,
    input  logic [7:0] code,
    output op_e        op
);

    always_comb begin
        op = OP_NONE;
        if (rs) begin
            op = rw ? OP_RDATA : OP_WDATA;
        end else if (rw) begin
            op = OP_STATUS;
        end else begin
            unique casez (code)
                8'b1???????: op = OP_SETDD;
                8'b01??????: op = OP_SETCG;
                8'b001?????: op = OP_FUNC;
                8'b0001????: op = OP_SHIFT;
                8'b00001???: op = OP_DISPCTL;
                8'b000001??: op = OP_ENTRY;
                8'b0000001?: op = OP_HOME;
                8'b00000001: op = OP_CLEAR;
                default:     op = OP_NONE;
            endcase
        end
    end

endmodule

// File: rtl/chardisp_step.sv
module chardisp_step #(
    parameter int ROW_LEN   = 40,
    parameter int ROW2_BASE = 64,
    parameter int AW        = 7,
    parameter int CIW       = 6
) (
    input  logic [AW-1:0] cur,
    input  logic          fwd,
    input  logic          cg_sel,
    output logic [AW-1:0] nxt
);

    localparam logic [AW-1:0] R1_LAST  = AW'(ROW_LEN - 1);
    localparam logic [AW-1:0] R2_FIRST = AW'(ROW2_BASE);
    localparam logic [AW-1:0] R2_LAST  = AW'(ROW2_BASE + ROW_LEN - 1);

    logic [CIW-1:0] cg_nxt;

    always_comb begin
        cg_nxt = fwd ? cur[CIW-1:0] + 1'b1 : cur[CIW-1:0] - 1'b1;
        if (cg_sel) begin
            nxt = {{(AW-CIW){1'b0}}, cg_nxt};
        end else if (fwd) begin
            if (cur == R1_LAST)       nxt = R2_FIRST;
            else if (cur >= R2_LAST)  nxt = '0;
            else                      nxt = cur + 1'b1;
        end else begin
            if (cur == R2_FIRST)                 nxt = R1_LAST;
            else if (cur == '0 || cur > R2_LAST) nxt = R2_LAST;
            else                                 nxt = cur - 1'b1;
        end
    end

endmodule

// File: rtl/chardisp_mem.sv
module chardisp_mem #(
    parameter int DD_ENTRIES = 80,
    parameter int CG_ENTRIES = 64,
    parameter int CG_W       = 5
) (
    input  logic                          clk,
    input  logic                          dd_we,
    input  logic [$clog2(DD_ENTRIES)-1:0] dd_idx,
    input  logic [7:0]                    dd_wdata,
    output logic [7:0]                    dd_rdata,
    input  logic                          cg_we,
    input  logic [$clog2(CG_ENTRIES)-1:0] cg_idx,
    input  logic [CG_W-1:0]               cg_wdata,
    output logic [CG_W-1:0]               cg_rdata
);

    logic [7:0]      dd_q [DD_ENTRIES];
    logic [CG_W-1:0] cg_q [CG_ENTRIES];

    always_ff @(posedge clk) begin
        if (dd_we) dd_q[dd_idx] <= dd_wdata;
        if (cg_we) cg_q[cg_idx] <= cg_wdata;
    end

    assign dd_rdata = dd_q[dd_idx];
    assign cg_rdata = cg_q[cg_idx];

endmodule

// File: rtl/chardisp_ctrl.sv
module chardisp_ctrl
    import chardisp_pkg::*;
#(
    parameter int ROW_LEN    = 40,
    parameter int ROW2_BASE  = 64,
    parameter int CG_ENTRIES = 64,
    parameter int CG_W       = 5,
    parameter int SHORT_CYC  = 4,
    parameter int LONG_CYC   = 96
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_stb,
    input  logic                       sel_data,
    input  logic                       rd_nwr,
    input  logic [7:0]                 wdata,
    output logic [7:0]                 rdata,
    output logic                       busy,
    output logic                       err,
    output logic [7:0]                 mode,
    output logic [$clog2(ROW_LEN)-1:0] disp_ofs
);

    localparam int AW         = 7;
    localparam int DD_ENTRIES = 2 * ROW_LEN;
    localparam int DIW        = $clog2(DD_ENTRIES);
    localparam int CIW        = $clog2(CG_ENTRIES);
    localparam int CW         = $clog2(LONG_CYC + 1);
    localparam int OFW        = $clog2(ROW_LEN);
    localparam logic [DIW-1:0] DD_LAST = DIW'(DD_ENTRIES - 1);
    localparam logic [OFW-1:0] OFS_MAX = OFW'(ROW_LEN - 1);

    st_e            st_q, st_d;
    logic [CW-1:0]  cnt_q, cnt_d;
    logic [DIW-1:0] wipe_q, wipe_d;
    logic [AW-1:0]  ac_q;
    logic           cg_sel_q;
    mode_t          mode_q;
    logic [OFW-1:0] ofs_q, ofs_up, ofs_dn;
    logic           err_q;
    logic [7:0]     rdata_q;

    op_e            op;
    logic           accept, reject;
    logic [AW-1:0]  ac_step, ac_move;
    logic           dd_valid;
    logic [DIW-1:0] dd_map;
    logic           dd_we, cg_we;
    logic [DIW-1:0] dd_idx;
    logic [7:0]     dd_wdata, dd_rdata;
    logic [CG_W-1:0] cg_rdata;

    chardisp_decode u_dec (.rs(sel_data), .rw(rd_nwr), .code(wdata), .op(op));

    chardisp_step #(.ROW_LEN(ROW_LEN), .ROW2_BASE(ROW2_BASE), .AW(AW), .CIW(CIW)) u_step_data (
        .cur(ac_q), .fwd(mode_q.inc), .cg_sel(cg_sel_q), .nxt(ac_step));

    chardisp_step #(.ROW_LEN(ROW_LEN), .ROW2_BASE(ROW2_BASE), .AW(AW), .CIW(CIW)) u_step_curs (
        .cur(ac_q), .fwd(wdata[2]), .cg_sel(cg_sel_q), .nxt(ac_move));

    chardisp_mem #(.DD_ENTRIES(DD_ENTRIES), .CG_ENTRIES(CG_ENTRIES), .CG_W(CG_W)) u_mem (
        .clk(clk), .dd_we(dd_we), .dd_idx(dd_idx), .dd_wdata(dd_wdata), .dd_rdata(dd_rdata),
        .cg_we(cg_we), .cg_idx(ac_q[CIW-1:0]), .cg_wdata(wdata[CG_W-1:0]), .cg_rdata(cg_rdata));

    assign busy   = (st_q != ST_READY);
    assign accept = wr_stb && !busy && (op != OP_STATUS) && (op != OP_NONE);
    assign reject = wr_stb &&  busy && (op != OP_STATUS);

    // display address to RAM index, gap marked invalid
    always_comb begin
        dd_valid = (ac_q <= AW'(ROW_LEN - 1)) ||
                   (ac_q >= AW'(ROW2_BASE) && ac_q <= AW'(ROW2_BASE + ROW_LEN - 1));
        dd_map   = (ac_q >= AW'(ROW2_BASE)) ? DIW'(ac_q - AW'(ROW2_BASE) + AW'(ROW_LEN))
                                            : DIW'(ac_q);
        ofs_up   = (ofs_q == OFS_MAX) ? '0 : ofs_q + 1'b1;
        ofs_dn   = (ofs_q == '0) ? OFS_MAX : ofs_q - 1'b1;
    end

    always_comb begin
        dd_we    = (st_q == ST_WIPE) ||
                   (accept && op == OP_WDATA && !cg_sel_q && dd_valid);
        dd_idx   = (st_q == ST_WIPE) ? wipe_q : dd_map;
        dd_wdata = (st_q == ST_WIPE) ? BLANK_CHAR : wdata;
        cg_we    = accept && op == OP_WDATA && cg_sel_q;
    end

    // next state
    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        wipe_d = wipe_q;
        unique case (st_q)
            ST_READY: if (accept) begin
                if (op == OP_CLEAR) begin
                    st_d   = ST_WIPE;
                    cnt_d  = CW'(LONG_CYC);
                    wipe_d = '0;
                end else begin
                    st_d  = ST_HOLD;
                    cnt_d = (op == OP_HOME) ? CW'(LONG_CYC) : CW'(SHORT_CYC);
                end
            end
            ST_WIPE: begin
                cnt_d  = (cnt_q > CW'(1)) ? cnt_q - 1'b1 : cnt_q;
                wipe_d = wipe_q + 1'b1;
                if (wipe_q == DD_LAST) st_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (cnt_q <= CW'(1)) st_d = ST_READY;
                else                 cnt_d = cnt_q - 1'b1;
            end
            default: st_d = ST_READY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_READY;
            cnt_q  <= '0;
            wipe_q <= '0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            wipe_q <= wipe_d;
        end
    end

    // registers and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ac_q     <= '0;
            cg_sel_q <= 1'b0;
            mode_q   <= mode_t'(MODE_RESET);
            ofs_q    <= '0;
            err_q    <= 1'b0;
            rdata_q  <= '0;
        end else begin
            if (reject) err_q <= 1'b1;
            if (wr_stb && op == OP_STATUS) rdata_q <= {busy, ac_q};
            if (accept) begin
                unique case (op)
                    OP_CLEAR, OP_HOME: begin
                        ac_q     <= '0;
                        ofs_q    <= '0;
                        cg_sel_q <= 1'b0;
                    end
                    OP_ENTRY: begin
                        mode_q.inc      <= wdata[1];
                        mode_q.shift_en <= wdata[0];
                    end
                    OP_DISPCTL: begin
                        mode_q.disp_on  <= wdata[2];
                        mode_q.cur_on   <= wdata[1];
                        mode_q.blink_on <= wdata[0];
                    end
                    OP_SHIFT: begin
                        if (wdata[3]) ofs_q <= wdata[2] ? ofs_up : ofs_dn;
                        else          ac_q  <= ac_move;
                    end
                    OP_FUNC: begin
                        mode_q.bus8     <= wdata[4];
                        mode_q.two_line <= wdata[3];
                        mode_q.font10   <= wdata[2];
                    end
                    OP_SETCG: begin
                        cg_sel_q <= 1'b1;
                        ac_q     <= {{(AW-CIW){1'b0}}, wdata[CIW-1:0]};
                    end
                    OP_SETDD: begin
                        cg_sel_q <= 1'b0;
                        ac_q     <= wdata[AW-1:0];
                    end
                    OP_WDATA: begin
                        ac_q <= ac_step;
                        if (mode_q.shift_en) ofs_q <= mode_q.inc ? ofs_up : ofs_dn;
                    end
                    OP_RDATA: begin
                        ac_q    <= ac_step;
                        rdata_q <= cg_sel_q ? {{(8-CG_W){1'b0}}, cg_rdata}
                                            : (dd_valid ? dd_rdata : 8'h00);
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rdata    = rdata_q;
    assign err      = err_q;
    assign mode     = mode_q;
    assign disp_ofs = ofs_q;

endmodule

// File: rtl/chardisp_chk.sv
module chardisp_chk #(
    parameter int ROW_LEN = 40
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_stb,
    input logic                       sel_data,
    input logic                       rd_nwr,
    input logic [7:0]                 wdata,
    input logic [7:0]                 rdata,
    input logic                       busy,
    input logic                       err,
    input logic [$clog2(ROW_LEN)-1:0] disp_ofs
);

    logic is_status, is_nop;
    assign is_status = !sel_data && rd_nwr;
    assign is_nop    = !sel_data && !rd_nwr && (wdata == 8'h00);

    a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !busy && !is_status && !is_nop) |=> busy);

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    a_r9_reject_sets_err: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && busy && !is_status) |=> err);

    a_r3_status_busy_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && is_status) |=> (rdata[7] == $past(busy)));

    a_r3_status_no_side_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && is_status && !busy) |=> (!busy && $stable(err)));

    a_r11_ofs_range: assert property (@(posedge clk) disable iff (!rst_n)
        disp_ofs < ($clog2(ROW_LEN))'(ROW_LEN));

endmodule

bind chardisp_ctrl chardisp_chk #(.ROW_LEN(ROW_LEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .sel_data(sel_data), .rd_nwr(rd_nwr),
    .wdata(wdata), .rdata(rdata), .busy(busy), .err(err), .disp_ofs(disp_ofs));

// File: tb/chardisp_ctrl_tb.sv
`timescale 1ns/1ps
module chardisp_ctrl_tb;

    localparam int SHORT = 4;
    localparam int LONG  = 96;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_stb = 1'b0, sel_data = 1'b0, rd_nwr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata, mode;
    logic       busy, err;
    logic [5:0] disp_ofs;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    bit         rd_pend = 1'b0;

    chardisp_ctrl #(.SHORT_CYC(SHORT), .LONG_CYC(LONG)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .sel_data(sel_data), .rd_nwr(rd_nwr),
        .wdata(wdata), .rdata(rdata), .busy(busy), .err(err), .mode(mode), .disp_ofs(disp_ofs));

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard when a read result is due
    always @(negedge clk) begin
        if (rd_pend) begin
            logic [7:0] e;
            string t;
            rd_pend = 1'b0;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(rdata == e, t, rdata, e);
        end
    end

    task automatic xfer(input bit rs, input bit rw, input logic [7:0] d, input bit is_rd);
        @(negedge clk);
        wr_stb = 1'b1; sel_data = rs; rd_nwr = rw; wdata = d;
        @(posedge clk);
        if (is_rd) rd_pend = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic wait_ready();
        while (busy) @(negedge clk);
    endtask

    task automatic cmd(input logic [7:0] d);
        xfer(1'b0, 1'b0, d, 1'b0);
        wait_ready();
    endtask

    task automatic wr(input logic [7:0] d);
        xfer(1'b1, 1'b0, d, 1'b0);
        wait_ready();
    endtask

    task automatic rdd(input logic [7:0] e, input string t);
        exp_q.push_back(e); tag_q.push_back(t);
        xfer(1'b1, 1'b1, 8'h00, 1'b1);
        wait_ready();
    endtask

    task automatic stat(input logic [7:0] e, input string t);
        exp_q.push_back(e); tag_q.push_back(t);
        xfer(1'b0, 1'b1, 8'h00, 1'b1);
    endtask

    task automatic measure(input int exp, input string t);
        int n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
        chk(n == exp, t, n, exp);
    endtask

    initial begin
        #(5.0 * 150000);
        checks++; errors++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(err == 1'b0, "R1 err", err, 0);
        chk(mode == 8'h82, "R1 mode", mode, 8'h82);
        chk(disp_ofs == 6'd0, "R1 ofs", disp_ofs, 0);
        chk(rdata == 8'h00, "R1 rdata", rdata, 0);
        stat(8'h00, "R3 status after reset");

        // R2 decode of mode instructions and no-op
        cmd(8'h38);
        chk(mode == 8'hC2, "R2 function set", mode, 8'hC2);
        cmd(8'h0F);
        chk(mode == 8'hDE, "R2 display control", mode, 8'hDE);
        cmd(8'h04);
        chk(mode == 8'hDC, "R2 entry mode", mode, 8'hDC);
        xfer(1'b0, 1'b0, 8'h00, 1'b0);
        chk(busy == 1'b0, "R2 zero byte no busy", busy, 0);

        // R8 short busy window
        xfer(1'b0, 1'b0, 8'h06, 1'b0);
        measure(SHORT, "R8 short busy");
        chk(mode == 8'hDE, "R2 entry restore", mode, 8'hDE);

        // R3 status while busy
        xfer(1'b0, 1'b0, 8'h80, 1'b0);
        stat(8'h80, "R3 status busy bit");
        wait_ready();
        chk(err == 1'b0, "R3 status no err", err, 0);

        // R4 write and read display RAM
        wr(8'h41); wr(8'h42);
        stat(8'h02, "R4 counter after writes");
        cmd(8'h80);
        rdd(8'h41, "R4 read first");
        rdd(8'h42, "R4 read second");

        // R5 gap crossing forward and back
        cmd(8'hA7);
        wr(8'h11); wr(8'h22);
        stat(8'h41, "R5 0x27 to 0x40");
        cmd(8'hC0);
        rdd(8'h22, "R5 data at 0x40");
        cmd(8'hE7);
        wr(8'h33);
        stat(8'h00, "R5 0x67 wraps to 0");
        rdd(8'h41, "R4 addr0 kept");
        cmd(8'h04);
        cmd(8'hC0);
        rdd(8'h22, "R5 read before back step");
        stat(8'h27, "R5 0x40 back to 0x27");
        cmd(8'h80);
        wr(8'h44);
        stat(8'h67, "R5 0 back to 0x67");
        cmd(8'h06);

        // R12 gap addresses
        cmd(8'hB0);
        wr(8'h55);
        cmd(8'hB0);
        rdd(8'h00, "R12 gap read zero");
        stat(8'h31, "R12 counter steps in gap");

        // R6 R7 pattern RAM
        cmd(8'h7F);
        wr(8'hFF);
        stat(8'h00, "R6 pattern address wraps");
        cmd(8'h7F);
        rdd(8'h1F, "R7 five-bit entry");
        cmd(8'h48);
        wr(8'h0A);
        cmd(8'h48);
        rdd(8'h0A, "R6 pattern readback");
        cmd(8'hC0);
        rdd(8'h22, "R6 display RAM untouched");

        // R9 transfer while busy dropped
        cmd(8'h85);
        xfer(1'b1, 1'b0, 8'h66, 1'b0);
        xfer(1'b1, 1'b0, 8'h77, 1'b0);
        wait_ready();
        chk(err == 1'b1, "R9 err set", err, 1);
        cmd(8'h85);
        rdd(8'h66, "R9 dropped write left RAM");
        stat(8'h06, "R9 counter not stepped");
        cmd(8'h06);
        chk(err == 1'b1, "R9 err sticky", err, 1);

        // R11 shifts
        cmd(8'h1C);
        chk(disp_ofs == 6'd1, "R11 shift right", disp_ofs, 1);
        cmd(8'h18); cmd(8'h18);
        chk(disp_ofs == 6'd39, "R11 shift left wraps", disp_ofs, 39);
        cmd(8'hA7);
        cmd(8'h14);
        stat(8'h40, "R11 cursor right over gap");
        cmd(8'h10);
        stat(8'h27, "R11 cursor left over gap");
        cmd(8'h07);
        wr(8'h01);
        chk(disp_ofs == 6'd0, "R11 write shift up", disp_ofs, 0);
        cmd(8'h05);
        wr(8'h02);
        chk(disp_ofs == 6'd39, "R11 write shift down", disp_ofs, 39);
        cmd(8'h06);

        // R10 home
        cmd(8'h48);
        xfer(1'b0, 1'b0, 8'h02, 1'b0);
        measure(LONG, "R8 home long busy");
        chk(disp_ofs == 6'd0, "R10 home ofs", disp_ofs, 0);
        stat(8'h00, "R10 home counter");
        rdd(8'h44, "R10 home keeps RAM and selects display");

        // R10 clear
        cmd(8'h50);
        cmd(8'h1C);
        xfer(1'b0, 1'b0, 8'h01, 1'b0);
        measure(LONG, "R8 clear long busy");
        chk(disp_ofs == 6'd0, "R10 clear ofs", disp_ofs, 0);
        stat(8'h00, "R10 clear counter");
        for (int i = 0; i < 80; i++) rdd(8'h20, "R10 clear fills spaces");
        stat(8'h00, "R5 full sweep wraps");
        cmd(8'h48);
        rdd(8'h0A, "R10 clear leaves pattern RAM");

        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule